// File: doc/BRIEF.md
# DMA Descriptor Configuration Checker

This block watches one DMA channel's transfer descriptor and flags settings that are inconsistent with one another. The checks cover three things. Addresses and offsets must be aligned to their transfer sizes. The byte count per minor loop must fit both transfer sizes. Channel priorities must be distinct when fixed-priority arbitration is in use. Two further checks run only when their own event occurs: the scatter-gather address alignment check and the minor-link bit consistency check.

Each class of error is reported at its own event. Alignment, byte-count and priority problems are reported when a channel is activated. A misaligned scatter-gather address is reported only when a major loop completes. A mismatched link bit is reported only when a minor loop completes. Every report updates a held status of error code and channel number, and it raises an interrupt pulse if that channel's error interrupt is enabled. The data transfers themselves take place elsewhere.

Top module: `desc_cfg_check`

## Requirements
- R1: At activation, a source address whose low log2(size) bits are not zero sets code bit 0. A source offset that fails the same test sets code bit 1.
- R2: At activation, a destination address that is misaligned to the destination size sets code bit 2. A destination offset that fails the same test sets code bit 3.
- R3: At activation, a minor loop byte count that is not a multiple of both the source and destination sizes sets code bit 4.
- R4: Size codes map as follows: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. A 1-byte size accepts any address, offset or byte count.
- R5: If fixed-priority mode is selected (`fixed_prio`=1) and two channels in the priority table hold the same level, activation sets code bit 7. If this is the only error bit, the reported channel is 0. In round-robin mode, duplicate levels are never an error.
- R6: With scatter-gather enabled, a scatter-gather address whose low 5 bits are not zero sets code bit 5. This is reported only on a major-loop-done strobe and never at activation.
- R7: With minor linking enabled, a current link bit that differs from the beginning link bit sets code bit 6. This is reported only on a minor-loop-done strobe.
- R8: `err_valid` pulses for exactly the one cycle after the strobe edge that found an error. In the same cycle, `err_code` and `err_chan` take the new values. They then hold until the next error.
- R9: `err_irq` pulses together with `err_valid` only when `irq_en[chan]` is 1.
- R10: After reset, all outputs are zero.
- R11: A cycle with no strobe reports nothing, whatever the descriptor holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_addr | input | 32 | Source start address |
| dst_addr | input | 32 | Destination start address |
| src_off | input | 16 | Signed source offset |
| dst_off | input | 16 | Signed destination offset |
| src_size | input | 2 | Source transfer size code |
| dst_size | input | 2 | Destination transfer size code |
| nbytes | input | 32 | Minor loop byte count |
| sg_en | input | 1 | Scatter-gather enable |
| sg_addr | input | 32 | Scatter-gather descriptor address |
| link_en | input | 1 | Minor loop link enable |
| cur_link | input | 1 | Current-iteration link bit |
| beg_link | input | 1 | Beginning-iteration link bit |
| chan | input | 4 | Channel that owns the descriptor and strobes |
| prio_tab | input | 64 | Per-channel priority levels, 4 bits each, channel 0 lowest |
| fixed_prio | input | 1 | 1 = fixed-priority arbitration |
| irq_en | input | 16 | Per-channel error interrupt enable |
| act_stb | input | 1 | Channel activation event |
| minor_stb | input | 1 | Minor loop completion event |
| major_stb | input | 1 | Major loop completion event |
| err_valid | output | 1 | One-cycle error report pulse |
| err_code | output | 8 | Held one-hot error class vector |
| err_chan | output | 4 | Held channel number of last error |
| err_irq | output | 1 | Gated error interrupt pulse |

## Verification
A fault in the error status register shows in the cycle right after a strobe. Either `err_code` carries the wrong class bit or comes out empty, or `err_valid` fails to pulse. A fault in the event gating puts the scatter-gather or link class at an activation, or it drops the class at its proper strobe. Both faults are visible one cycle after the edge that sampled the strobe. A stale or drifting status shows up as a code or channel that changes in a cycle with no error pulse.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int CODE_W   = 8;
    localparam int B_SADDR  = 0;
    localparam int B_SOFF   = 1;
    localparam int B_DADDR  = 2;
    localparam int B_DOFF   = 3;
    localparam int B_NBYTES = 4;
    localparam int B_SG     = 5;
    localparam int B_LINK   = 6;
    localparam int B_PRIO   = 7;
    localparam int SG_ALIGN_BITS = 5;

    // Low-bit mask that must be zero for a value aligned to the size code.
    function automatic logic [2:0] size_mask(input logic [1:0] sz);
        logic [3:0] m;
        m = (4'd1 << sz) - 4'd1;
        return m[2:0];
    endfunction
endpackage

// File: rtl/dcc_align.sv
module dcc_align #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [OW-1:0] off,
    input  logic [1:0]    size,
    output logic          addr_bad,
    output logic          off_bad
);
    import dcc_pkg::*;
    logic [2:0] mask;

    always_comb begin
        mask     = size_mask(size);
        addr_bad = |(addr[2:0] & mask);
        off_bad  = |(off[2:0] & mask);
    end
endmodule

// File: rtl/dcc_prio_dup.sv
module dcc_prio_dup #(
    parameter int NCH = 16,
    parameter int PW  = 4
) (
    input  logic [NCH*PW-1:0] prio,
    output logic              dup
);
    localparam int NHIT = NCH * NCH;
    logic [NHIT-1:0] hit;

    for (genvar i = 0; i < NCH; i++) begin : g_row
        for (genvar j = 0; j < NCH; j++) begin : g_col
            if (j > i) begin : g_cmp
                assign hit[i*NCH+j] = (prio[i*PW +: PW] == prio[j*PW +: PW]);
            end else begin : g_off
                assign hit[i*NCH+j] = 1'b0;
            end
        end
    end

    assign dup = |hit;
endmodule

// File: rtl/dcc_report.sv
module dcc_report #(
    parameter int NCH = 16,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [dcc_pkg::CODE_W-1:0] evt_code,
    input  logic [CHW-1:0]            chan,
    input  logic [NCH-1:0]            irq_en,
    output logic                      err_valid,
    output logic [dcc_pkg::CODE_W-1:0] err_code,
    output logic [CHW-1:0]            err_chan,
    output logic                      err_irq
);
    import dcc_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
        logic [CHW-1:0]    chan;
        logic              irq;
    } rep_t;

    localparam logic [CODE_W-1:0] PRIO_ONLY = CODE_W'(1) << B_PRIO;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d       = rep_q;
        rep_d.valid = |evt_code;
        rep_d.irq   = 1'b0;
        if (|evt_code) begin
            rep_d.code = evt_code;
            rep_d.chan = (evt_code == PRIO_ONLY) ? '0 : chan;
            rep_d.irq  = irq_en[chan];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rep_q <= '0;
        else        rep_q <= rep_d;
    end

    assign err_valid = rep_q.valid;
    assign err_code  = rep_q.code;
    assign err_chan  = rep_q.chan;
    assign err_irq   = rep_q.irq;

    AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> err_valid); // R9
    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_code != '0)); // R8
    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !err_valid |-> ($stable(err_code) && $stable(err_chan))); // R8
    AST_PRIO_NO_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code == PRIO_ONLY) |-> (err_chan == '0)); // R5
endmodule

// File: rtl/desc_cfg_check.sv
module desc_cfg_check #(
    parameter int NCH = 16,
    parameter int PW  = 4,
    parameter int AW  = 32,
    parameter int OW  = 16,
    parameter int BW  = 32,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     src_addr,
    input  logic [AW-1:0]     dst_addr,
    input  logic [OW-1:0]     src_off,
    input  logic [OW-1:0]     dst_off,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic [BW-1:0]     nbytes,
    input  logic              sg_en,
    input  logic [AW-1:0]     sg_addr,
    input  logic              link_en,
    input  logic              cur_link,
    input  logic              beg_link,
    input  logic [CHW-1:0]    chan,
    input  logic [NCH*PW-1:0] prio_tab,
    input  logic              fixed_prio,
    input  logic [NCH-1:0]    irq_en,
    input  logic              act_stb,
    input  logic              minor_stb,
    input  logic              major_stb,
    output logic              err_valid,
    output logic [7:0]        err_code,
    output logic [CHW-1:0]    err_chan,
    output logic              err_irq
);
    import dcc_pkg::*;

    logic src_addr_bad, src_off_bad, dst_addr_bad, dst_off_bad;
    logic prio_dup;
    logic [CODE_W-1:0] evt_code;

    dcc_align #(.AW(AW), .OW(OW)) u_src_align (
        .addr(src_addr), .off(src_off), .size(src_size),
        .addr_bad(src_addr_bad), .off_bad(src_off_bad)
    );

    dcc_align #(.AW(AW), .OW(OW)) u_dst_align (
        .addr(dst_addr), .off(dst_off), .size(dst_size),
        .addr_bad(dst_addr_bad), .off_bad(dst_off_bad)
    );

    dcc_prio_dup #(.NCH(NCH), .PW(PW)) u_prio_dup (
        .prio(prio_tab), .dup(prio_dup)
    );

    always_comb begin
        logic [2:0] nb_mask;
        nb_mask  = size_mask(src_size) | size_mask(dst_size);
        evt_code = '0;
        if (act_stb) begin
            evt_code[B_SADDR]  = src_addr_bad;
            evt_code[B_SOFF]   = src_off_bad;
            evt_code[B_DADDR]  = dst_addr_bad;
            evt_code[B_DOFF]   = dst_off_bad;
            evt_code[B_NBYTES] = |(nbytes[2:0] & nb_mask);
            evt_code[B_PRIO]   = fixed_prio & prio_dup;
        end
        if (major_stb && sg_en)
            evt_code[B_SG] = |sg_addr[SG_ALIGN_BITS-1:0];
        if (minor_stb && link_en)
            evt_code[B_LINK] = (cur_link != beg_link);
    end

    dcc_report #(.NCH(NCH)) u_report (
        .clk(clk), .rst_n(rst_n), .evt_code(evt_code), .chan(chan),
        .irq_en(irq_en), .err_valid(err_valid), .err_code(err_code),
        .err_chan(err_chan), .err_irq(err_irq)
    );

    AST_SG_AT_MAJOR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code[B_SG]) |-> $past(major_stb)); // R6
    AST_LINK_AT_MINOR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_code[B_LINK]) |-> $past(minor_stb)); // R7
    AST_ACT_CLASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && (|err_code[B_NBYTES:B_SADDR] || err_code[B_PRIO])) |-> $past(act_stb)); // R1
    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_stb || minor_stb || major_stb) |=> !err_valid); // R11
endmodule

// File: tb/desc_cfg_check_bench.sv
module desc_cfg_check_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_addr, dst_addr, nbytes, sg_addr;
    logic [15:0] src_off, dst_off;
    logic [1:0]  src_size, dst_size;
    logic        sg_en, link_en, cur_link, beg_link;
    logic [3:0]  chan;
    logic [63:0] prio_tab;
    logic        fixed_prio;
    logic [15:0] irq_en;
    logic        act_stb = 1'b0, minor_stb = 1'b0, major_stb = 1'b0;
    logic        err_valid, err_irq;
    logic [7:0]  err_code;
    logic [3:0]  err_chan;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    desc_cfg_check u_desc_cfg_check (
        .clk(clk), .rst_n(rst_n), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_off(src_off), .dst_off(dst_off), .src_size(src_size),
        .dst_size(dst_size), .nbytes(nbytes), .sg_en(sg_en), .sg_addr(sg_addr),
        .link_en(link_en), .cur_link(cur_link), .beg_link(beg_link),
        .chan(chan), .prio_tab(prio_tab), .fixed_prio(fixed_prio),
        .irq_en(irq_en), .act_stb(act_stb), .minor_stb(minor_stb),
        .major_stb(major_stb), .err_valid(err_valid), .err_code(err_code),
        .err_chan(err_chan), .err_irq(err_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_rep(input string tag, input logic v, input logic [7:0] code,
                              input logic [3:0] ch, input logic irq);
        chk({tag, " valid"}, {31'd0, err_valid}, {31'd0, v});
        chk({tag, " code"}, {24'd0, err_code}, {24'd0, code});
        chk({tag, " chan"}, {28'd0, err_chan}, {28'd0, ch});
        chk({tag, " irq"}, {31'd0, err_irq}, {31'd0, irq});
    endtask

    task automatic set_good();
        src_addr = 32'h1000; dst_addr = 32'h2000;
        src_off = 16'd4; dst_off = 16'd4;
        src_size = 2'd2; dst_size = 2'd2; nbytes = 32'd16;
        sg_en = 1'b0; sg_addr = 32'h3000;
        link_en = 1'b0; cur_link = 1'b0; beg_link = 1'b0;
        chan = 4'd5; fixed_prio = 1'b1; irq_en = 16'hFFFF;
        for (int i = 0; i < 16; i++) prio_tab[i*4 +: 4] = 4'(i);
    endtask

    // Strobe for one edge; return at the following negedge, where the report is visible.
    task automatic fire(input logic a, input logic mi, input logic ma);
        @(negedge clk);
        act_stb = a; minor_stb = mi; major_stb = ma;
        @(negedge clk);
        act_stb = 1'b0; minor_stb = 1'b0; major_stb = 1'b0;
    endtask

    task automatic t_reset();
        expect_rep("R10 reset", 1'b0, 8'h00, 4'd0, 1'b0);
    endtask

    task automatic t_src();
        set_good(); fire(1, 0, 0);
        expect_rep("R1 clean", 1'b0, 8'h00, 4'd0, 1'b0);
        src_addr = 32'h1002; fire(1, 0, 0);
        expect_rep("R1 src addr", 1'b1, 8'h01, 4'd5, 1'b1);
        set_good(); src_off = 16'hFFFE; fire(1, 0, 0);
        expect_rep("R1 src off", 1'b1, 8'h02, 4'd5, 1'b1);
        src_size = 2'd1; nbytes = 32'd16; fire(1, 0, 0);
        chk("R4 2-byte offset ok", {31'd0, err_valid}, 32'd0);
    endtask

    task automatic t_dst();
        set_good(); dst_size = 2'd3; dst_addr = 32'h2004; dst_off = 16'd8; fire(1, 0, 0);
        expect_rep("R2 dst addr", 1'b1, 8'h04, 4'd5, 1'b1);
        dst_addr = 32'h2008; dst_off = 16'd4; fire(1, 0, 0);
        expect_rep("R2 dst off", 1'b1, 8'h08, 4'd5, 1'b1);
        dst_addr = 32'h2001; chan = 4'd9; fire(1, 0, 0);
        expect_rep("R2 both", 1'b1, 8'h0C, 4'd9, 1'b1);
    endtask

    task automatic t_nbytes();
        set_good(); src_size = 2'd0; src_addr = 32'h1003; src_off = 16'd1;
        nbytes = 32'd6; fire(1, 0, 0);
        expect_rep("R3 nbytes", 1'b1, 8'h10, 4'd5, 1'b1);
        nbytes = 32'd8; fire(1, 0, 0);
        chk("R4 1-byte any addr", {31'd0, err_valid}, 32'd0);
        set_good(); src_size = 2'd3; src_addr = 32'h1008; src_off = 16'd8;
        nbytes = 32'd12; fire(1, 0, 0);
        expect_rep("R3 R4 8-byte", 1'b1, 8'h10, 4'd5, 1'b1);
    endtask

    task automatic t_hold();
        @(negedge clk);
        expect_rep("R8 held", 1'b0, 8'h10, 4'd5, 1'b0);
        set_good(); src_addr = 32'h1001; nbytes = 32'd3;
        repeat (3) @(negedge clk);
        expect_rep("R11 no strobe", 1'b0, 8'h10, 4'd5, 1'b0);
    endtask

    task automatic t_prio();
        set_good(); chan = 4'd3; prio_tab[7*4 +: 4] = 4'd2; fire(1, 0, 0);
        expect_rep("R5 dup", 1'b1, 8'h80, 4'd0, 1'b1);
        fixed_prio = 1'b0; fire(1, 0, 0);
        chk("R5 round robin", {31'd0, err_valid}, 32'd0);
        fixed_prio = 1'b1; src_addr = 32'h1002; fire(1, 0, 0);
        expect_rep("R5 dup plus src", 1'b1, 8'h81, 4'd3, 1'b1);
        set_good(); chan = 4'd3; fire(1, 0, 0);
        chk("R5 unique", {31'd0, err_valid}, 32'd0);
    endtask

    task automatic t_sg();
        set_good(); sg_en = 1'b1; sg_addr = 32'h3010; fire(1, 0, 0);
        chk("R6 not at act", {31'd0, err_valid}, 32'd0);
        fire(0, 1, 0);
        chk("R6 not at minor", {31'd0, err_valid}, 32'd0);
        fire(0, 0, 1);
        expect_rep("R6 at major", 1'b1, 8'h20, 4'd5, 1'b1);
        sg_en = 1'b0; fire(0, 0, 1);
        chk("R6 disabled", {31'd0, err_valid}, 32'd0);
        sg_en = 1'b1; sg_addr = 32'h3020; fire(0, 0, 1);
        chk("R6 aligned", {31'd0, err_valid}, 32'd0);
    endtask

    task automatic t_link();
        set_good(); link_en = 1'b1; cur_link = 1'b1; chan = 4'd12; fire(1, 0, 0);
        chk("R7 not at act", {31'd0, err_valid}, 32'd0);
        fire(0, 0, 1);
        chk("R7 not at major", {31'd0, err_valid}, 32'd0);
        fire(0, 1, 0);
        expect_rep("R7 at minor", 1'b1, 8'h40, 4'd12, 1'b1);
        link_en = 1'b0; fire(0, 1, 0);
        chk("R7 disabled", {31'd0, err_valid}, 32'd0);
        link_en = 1'b1; beg_link = 1'b1; fire(0, 1, 0);
        chk("R7 equal", {31'd0, err_valid}, 32'd0);
    endtask

    task automatic t_irq();
        set_good(); irq_en = 16'hFFFF & ~(16'd1 << 5); src_addr = 32'h1001; fire(1, 0, 0);
        expect_rep("R9 masked", 1'b1, 8'h01, 4'd5, 1'b0);
        chan = 4'd6; fire(1, 0, 0);
        expect_rep("R9 enabled", 1'b1, 8'h01, 4'd6, 1'b1);
    endtask

    initial begin
        set_good();
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_src();
        t_dst();
        t_nbytes();
        t_hold();
        t_prio();
        t_sg();
        t_link();
        t_irq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule